// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two independent ports of a shared 4K-word memory and settles what happens when both of them select the same word at once. On every rising clock edge it compares the two chip enables and the two 12-bit addresses. If both ports are enabled on one address, the port whose request was already steady on the previous edge keeps the word. The other port sees an active-low busy and cannot write. A port's request counts as steady when it was enabled with the same address on both edges. If both ports arrive on the same edge, the left port wins by fixed priority. Reads and writes are treated the same way when deciding the winner. The write strobe handed on to the array is gated by the result.

A mode input lets several of these arbiters run side by side to build a wider word. In master mode the arbiter drives the two busy outputs itself. In slave mode the busy outputs stay high. Each port then takes a busy input from an external master, and that input does nothing except block writes on its own port.

Top module: `dpca_arbiter`

## Requirements
- R1: In master mode, a busy output is low only when, at the previous rising edge, both enables were high and the two addresses were equal. One cycle after either enable goes low or the addresses differ, both busy outputs are high.
- R2: When the match begins, if one port's request (enable high and the same address) was already held on the previous edge and the other port's request is new, the held port wins. The busy output of the new port goes low one cycle after the match begins.
- R3: If both requests are new, or both were already held, when the match begins, the left port wins and right busy goes low.
- R4: The two busy outputs are never low at the same time.
- R5: The winner keeps its win for as long as the match lasts, even when the read/write inputs change. The win is released one cycle after the match ends.
- R6: The read/write inputs have no effect on which port wins.
- R7: The gated write output of a port is high exactly when that port's enable and write inputs are high and the port is not inhibited. In master mode a port is inhibited while its own busy output is low.
- R8: In slave mode both busy outputs are held high. A port is inhibited, within the same cycle, whenever its busy input is low, and a high busy input leaves its writes alone.
- R9: While reset is asserted, both busy outputs are high and no ownership is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master (busy driven out), 0 = slave (busy taken in) |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | 12 | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_in_n | input | 1 | Left port busy input in slave mode, active low |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | 12 | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_in_n | input | 1 | Right port busy input in slave mode, active low |
| l_busy_n | output | 1 | Left port busy, active low |
| r_busy_n | output | 1 | Right port busy, active low |
| l_wr_ok | output | 1 | Gated write strobe for the left port |
| r_wr_ok | output | 1 | Gated write strobe for the right port |

## Verification
The arbitration result is stored on the edge that samples a new match, so both busy outputs are due one cycle after the stimulus. The gated write outputs are combinational, formed from that stored result together with the enable, write and busy inputs that are still being applied. A driver task sets the inputs half a period before an edge and queues the expected values for that edge. The monitor reads the outputs 2 ns after the edge, before the inputs move again, so each busy value is checked in its due cycle and each write-gate value is checked against inputs that have not yet changed. The slave-mode checks compare the write-gate outputs in the same cycle the busy input changes, which shows that a busy input passes straight through without a register.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;
endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              prev_en_q, prev_en_d;
  logic [ADDR_W-1:0] prev_addr_q, prev_addr_d;
  logic              upd;

  always_comb begin
    upd         = 1'b1;
    prev_en_d   = en;
    prev_addr_d = addr;
    settled     = en && prev_en_q && (addr == prev_addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else if (upd) begin
      prev_en_q   <= prev_en_d;
      prev_addr_q <= prev_addr_d;
    end
  end
endmodule

// File: rtl/dpca_owner_fsm.sv
module dpca_owner_fsm
  import dpca_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   match,
  input  logic   l_settled,
  input  logic   r_settled,
  output owner_t owner
);
  owner_t owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    if (!match) begin
      owner_d = OWN_NONE;
    end else if (owner_q == OWN_NONE) begin
      if (r_settled && !l_settled) owner_d = OWN_RIGHT;
      else                         owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign owner = owner_q;
endmodule

// File: rtl/dpca_wr_gate.sv
module dpca_wr_gate (
  input  logic master_mode,
  input  logic en,
  input  logic wr,
  input  logic lost,
  input  logic busy_in_n,
  output logic busy_n,
  output logic wr_ok
);
  logic inhibit;

  always_comb begin
    if (master_mode) begin
      busy_n  = !lost;
      inhibit = lost;
    end else begin
      busy_n  = 1'b1;
      inhibit = !busy_in_n;
    end
    wr_ok = en && wr && !inhibit;
  end
endmodule

// File: rtl/dpca_arbiter.sv
module dpca_arbiter
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_busy_in_n,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]  p_en, p_wr, p_bin, p_settled, p_lost, p_busy, p_ok;
  logic [ADDR_W-1:0] p_addr [NPORT];
  logic              match;
  owner_t            owner;

  assign p_en     = {r_en, l_en};
  assign p_wr     = {r_wr, l_wr};
  assign p_bin    = {r_busy_in_n, l_busy_in_n};
  assign p_addr[0] = l_addr;
  assign p_addr[1] = r_addr;
  assign match    = l_en && r_en && (l_addr == r_addr);
  assign p_lost[0] = (owner == OWN_RIGHT);
  assign p_lost[1] = (owner == OWN_LEFT);

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (p_en[g]),
      .addr    (p_addr[g]),
      .settled (p_settled[g])
    );
    dpca_wr_gate u_gate (
      .master_mode (master_mode),
      .en          (p_en[g]),
      .wr          (p_wr[g]),
      .lost        (p_lost[g]),
      .busy_in_n   (p_bin[g]),
      .busy_n      (p_busy[g]),
      .wr_ok       (p_ok[g])
    );
  end

  dpca_owner_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .l_settled (p_settled[0]),
    .r_settled (p_settled[1]),
    .owner     (owner)
  );

  assign l_busy_n = p_busy[0];
  assign r_busy_n = p_busy[1];
  assign l_wr_ok  = p_ok[0];
  assign r_wr_ok  = p_ok[1];
endmodule

// File: rtl/dpca_arbiter_chk.sv
module dpca_arbiter_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              l_busy_in_n,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_ok,
  input logic              r_wr_ok
);
  logic hit;
  assign hit = l_en && r_en && (l_addr == r_addr);

  // R1
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> $past(hit));

  // R4
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  // R5
  win_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !r_busy_n && hit) |=> (!master_mode || !r_busy_n));

  // R7
  left_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n) |-> !l_wr_ok);

  // R7
  right_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !r_busy_n) |-> !r_wr_ok);

  // R8
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n));

  // R8
  slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (!l_busy_in_n || !r_busy_in_n)) |->
      ((l_busy_in_n || !l_wr_ok) && (r_busy_in_n || !r_wr_ok)));
endmodule

bind dpca_arbiter dpca_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dpca_arbiter_test.sv
module dpca_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master_mode = 1'b1;
  logic        l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic        l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic        l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  lb, rb, lw, rw;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dpca_arbiter uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in_n(l_busy_in_n),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  task automatic cmp(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic ms, input logic le, input logic [11:0] la, input logic lwr,
                       input logic re, input logic [11:0] ra, input logic rwr,
                       input logic lbi, input logic rbi,
                       input logic elb, input logic erb, input logic elw, input logic erw,
                       input string tag);
    exp_t e;
    @(negedge clk);
    master_mode = ms; l_en = le; l_addr = la; l_wr = lwr;
    r_en = re; r_addr = ra; r_wr = rwr; l_busy_in_n = lbi; r_busy_in_n = rbi;
    e.lb = elb; e.rb = erb; e.lw = elw; e.rw = erw; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        cmp(l_busy_n, e.lb, e.tag, "l_busy_n");
        cmp(r_busy_n, e.rb, e.tag, "r_busy_n");
        cmp(l_wr_ok,  e.lw, e.tag, "l_wr_ok");
        cmp(r_wr_ok,  e.rw, e.tag, "r_wr_ok");
      end
    end
  end

  initial begin : watchdog
    #(8 * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp(l_busy_n, 1'b1, "R9", "l_busy_n");
    cmp(r_busy_n, 1'b1, "R9", "r_busy_n");
    rst_n = 1'b1;
    //      ms le la     lw re ra     rw lbi rbi  lb rb lw rw
    drive(1, 0, 12'h000, 0, 0, 12'h000, 0, 1, 1,  1, 1, 0, 0, "R1 idle");
    drive(1, 1, 12'h005, 1, 0, 12'h005, 0, 1, 1,  1, 1, 1, 0, "R7 left alone");
    drive(1, 1, 12'h005, 1, 1, 12'h005, 1, 1, 1,  1, 0, 1, 0, "R2 left held wins");
    drive(1, 1, 12'h005, 1, 1, 12'h005, 1, 1, 1,  1, 0, 1, 0, "R5 hold");
    drive(1, 1, 12'h005, 1, 1, 12'h006, 1, 1, 1,  1, 1, 1, 1, "R1 release");
    drive(1, 1, 12'h006, 1, 1, 12'h006, 1, 1, 1,  0, 1, 0, 1, "R2 right held wins");
    drive(1, 1, 12'h006, 0, 1, 12'h006, 0, 1, 1,  0, 1, 0, 0, "R6 rw toggles");
    drive(1, 0, 12'h006, 1, 1, 12'h006, 1, 1, 1,  1, 1, 0, 1, "R5 release on enable");
    drive(1, 0, 12'h000, 0, 0, 12'h000, 0, 1, 1,  1, 1, 0, 0, "R1 idle");
    drive(1, 1, 12'hFFF, 1, 1, 12'hFFF, 1, 1, 1,  1, 0, 1, 0, "R3 tie left");
    drive(1, 1, 12'h007, 1, 1, 12'h009, 1, 1, 1,  1, 1, 1, 1, "R1 no match");
    drive(0, 1, 12'h007, 1, 1, 12'h007, 1, 1, 0,  1, 1, 1, 0, "R8 slave right inhib");
    drive(0, 1, 12'h007, 1, 1, 12'h007, 1, 0, 1,  1, 1, 0, 1, "R8 slave left inhib");
    drive(1, 1, 12'h007, 1, 1, 12'h007, 1, 0, 1,  1, 0, 1, 0, "R4 master again");
    drive(1, 1, 12'h007, 0, 1, 12'h007, 1, 1, 1,  1, 0, 0, 0, "R6 read keeps win");
    drive(1, 0, 12'h000, 0, 0, 12'h000, 0, 1, 1,  1, 1, 0, 0, "R1 idle end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule